// File: doc/BRIEF.md
# Ping-Pong Sample Stream Buffer

This block takes a continuous stream of fixed-width samples and stores them in two equal memory banks with no processor involvement for each sample. The stream side fills one bank while the processor reads the other one through a bank-relative read port. Once the stream side has written a full block, the two banks exchange roles. A one-cycle interrupt pulse then tells the processor that a fresh block is ready in the bank it now owns.

The processor acknowledges each interrupt. If a second exchange arrives before the previous interrupt has been acknowledged, the processor has fallen behind. A sticky overrun flag records this, and it stays set until the processor clears it. The block length and the sample width are parameters.

Top module: `pingpong_buf`

## Requirements
- R1: While reset is held, `inReady` and `irqPulse` are 0, `overrun` is 0 and `cpuBank` is 1, which means the stream side owns bank 0. The first sample accepted after reset lands at address 0 of bank 0.
- R2: `inReady` is 1 from the first clock edge after reset is released. A sample is taken only on an edge where both `inValid` and `inReady` are 1. Cycles with `inValid` low do not advance the write position.
- R3: On the edge that accepts the BLOCK_LEN-th sample of a block, `cpuBank` inverts and `irqPulse` goes to 1 in the same cycle. `irqPulse` lasts exactly one cycle. `cpuBank` never changes without `irqPulse`.
- R4: Within a block, sample k in arrival order (k counting from 0) is stored at address k of the bank being filled. `rdData` shows the word at `rdAddr` in bank `cpuBank` one clock edge after `rdAddr` is sampled.
- R5: Samples being written into the stream-side bank never change what the processor reads. During block n+1 the processor reads the unchanged words of block n.
- R6: Each exchange leaves an interrupt pending until `ackIrq` is sampled high. An exchange that finds an interrupt pending sets `overrun`, unless `ackIrq` is high on that same edge; in that case the ack retires the older interrupt and `overrun` is not set.
- R7: `overrun` stays 1 until `clrOverrun` is sampled high. If a new overrun and `clrOverrun` occur on the same edge, `overrun` ends up 1.
- R8: `ackIrq` while no interrupt is pending has no effect: it produces no pulse, no bank change and no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Stream sample is valid |
| inReady | output | 1 | Stream side can accept a sample |
| inData | input | DATA_W | Stream sample |
| rdAddr | input | ADDR_W | Processor read address within its bank |
| rdData | output | DATA_W | Read word, one cycle after rdAddr |
| ackIrq | input | 1 | Processor acknowledges the last interrupt |
| clrOverrun | input | 1 | Clears the overrun flag |
| irqPulse | output | 1 | One-cycle block-done interrupt |
| cpuBank | output | 1 | Bank currently owned by the processor |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench inputs are driven on the falling edge, so every rising edge captures them.

- **Exchange, interrupt and overrun (R3, R6, R7):** `cpuBank`, `irqPulse` and `overrun` all change on the rising edge that captures the final sample, or the ack or clear. The bench samples them at the next falling edge. It checks `irqPulse` low again one cycle later.
- **Reads (R4, R5):** read data comes from a single output register. The driver records each expected word on the falling edge where it presents `rdAddr`. A flag captured on the rising edge tells the monitor to compare the result on the following falling edge.

// File: rtl/pp_pkg.sv
package pp_pkg;

  // Strobes from control to datapath, valid in the cycle they are driven.
  typedef struct packed {
    logic wrEn;    // write inData this edge
    logic wrBank;  // bank being filled by the stream side
    logic rdBank;  // bank owned by the processor
  } ppStrobes_t;

endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int BLOCK_LEN = 64,
  parameter int ADDR_W    = $clog2(BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              ackIrq,
  input  logic              clrOverrun,
  output logic              inReady,
  output logic [ADDR_W-1:0] wrAddr,
  output ppStrobes_t        strobes,
  output logic              irqPulse,
  output logic              cpuBank,
  output logic              overrun
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BLOCK_LEN - 1);

  logic              readyQ;
  logic [ADDR_W-1:0] wrPtr;
  logic              fillBank;
  logic              pendingQ;
  logic              overrunQ;
  logic              irqQ;

  logic acceptS;
  logic lastS;
  logic swapS;

  always_comb begin
    acceptS = inValid && readyQ;
    lastS   = (wrPtr == LAST_ADDR);
    swapS   = acceptS && lastS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ   <= 1'b0;
      wrPtr    <= '0;
      fillBank <= 1'b0;
      pendingQ <= 1'b0;
      overrunQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      if (acceptS) begin
        wrPtr <= lastS ? '0 : wrPtr + 1'b1;
      end
      if (swapS) begin
        fillBank <= ~fillBank;
      end
      irqQ     <= swapS;
      pendingQ <= swapS | (pendingQ & ~ackIrq);
      overrunQ <= (swapS & pendingQ & ~ackIrq) | (overrunQ & ~clrOverrun);
    end
  end

  always_comb begin
    strobes.wrEn   = acceptS;
    strobes.wrBank = fillBank;
    strobes.rdBank = ~fillBank;
  end

  assign inReady  = readyQ;
  assign wrAddr   = wrPtr;
  assign irqPulse = irqQ;
  assign cpuBank  = ~fillBank;
  assign overrun  = overrunQ;

endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLOCK_LEN = 64,
  parameter int ADDR_W    = $clog2(BLOCK_LEN)
) (
  input  logic              clk,
  input  ppStrobes_t        strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int NUM_BANKS = 2;

  logic [DATA_W-1:0] bankWord [NUM_BANKS];

  for (genvar bankIdx = 0; bankIdx < NUM_BANKS; bankIdx++) begin : g_bank
    logic [DATA_W-1:0] mem [BLOCK_LEN];

    always_ff @(posedge clk) begin
      if (strobes.wrEn && (strobes.wrBank == 1'(bankIdx))) begin
        mem[wrAddr] <= wrData;
      end
    end

    assign bankWord[bankIdx] = mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    rdData <= bankWord[strobes.rdBank];
  end

endmodule

// File: rtl/pingpong_buf.sv
module pingpong_buf
  import pp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLOCK_LEN = 64,
  localparam int ADDR_W   = $clog2(BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              ackIrq,
  input  logic              clrOverrun,
  output logic              irqPulse,
  output logic              cpuBank,
  output logic              overrun
);

  ppStrobes_t        strobes;
  logic [ADDR_W-1:0] wrAddr;

  pp_ctrl #(
    .BLOCK_LEN(BLOCK_LEN),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .ackIrq    (ackIrq),
    .clrOverrun(clrOverrun),
    .inReady   (inReady),
    .wrAddr    (wrAddr),
    .strobes   (strobes),
    .irqPulse  (irqPulse),
    .cpuBank   (cpuBank),
    .overrun   (overrun)
  );

  pp_datapath #(
    .DATA_W   (DATA_W),
    .BLOCK_LEN(BLOCK_LEN),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk    (clk),
    .strobes(strobes),
    .wrAddr (wrAddr),
    .wrData (inData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

endmodule

// File: rtl/pp_checker.sv
module pp_checker (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic ackIrq,
  input logic clrOverrun,
  input logic irqPulse,
  input logic cpuBank,
  input logic overrun
);

  p_ready_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> inReady);

  p_irq_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  p_swap_has_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuBank != $past(cpuBank)) |-> irqPulse);

  p_irq_has_swap_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (cpuBank != $past(cpuBank)));

  p_overrun_on_swap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> irqPulse);

  p_overrun_needs_ack_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> !$past(ackIrq));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> $past(clrOverrun));

endmodule

bind pingpong_buf pp_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .ackIrq    (ackIrq),
  .clrOverrun(clrOverrun),
  .irqPulse  (irqPulse),
  .cpuBank   (cpuBank),
  .overrun   (overrun)
);

// File: tb/pingpong_buf_tb.sv
module pingpong_buf_tb;

  localparam int DATA_W    = 16;
  localparam int BLOCK_LEN = 64;
  localparam int ADDR_W    = $clog2(BLOCK_LEN);

  typedef struct {
    logic [DATA_W-1:0] val;
    string             tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [DATA_W-1:0] inData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              ackIrq = 1'b0;
  logic              clrOverrun = 1'b0;
  logic              irqPulse;
  logic              cpuBank;
  logic              overrun;

  int  checks = 0;
  int  fails  = 0;
  logic expBank = 1'b1;
  logic rdReq = 1'b0;
  logic rspDue = 1'b0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  pingpong_buf #(.DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .rdAddr(rdAddr), .rdData(rdData), .ackIrq(ackIrq),
    .clrOverrun(clrOverrun), .irqPulse(irqPulse), .cpuBank(cpuBank),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] sampleVal(input int blk, input int idx);
    return DATA_W'((blk << 8) | idx);
  endfunction

  // Monitor: responses are due one edge after a request.
  always @(posedge clk) rspDue <= rdReq;

  always @(negedge clk) begin
    if (rspDue) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R4 queue", 32'(rdData), 32'hx);
      end else begin
        expItem_t item;
        item = expQ.pop_front();
        chk(rdData === item.val, item.tag, 32'(rdData), 32'(item.val));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulseAck();
    ackIrq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ackIrq = 1'b0;
    chk(irqPulse == 1'b0, "R8 irq", 32'(irqPulse), 0);
  endtask

  task automatic pulseClr();
    clrOverrun = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clrOverrun = 1'b0;
  endtask

  // Streams one block; optional idle gaps, reads of the previous block,
  // and ack/clear on the last sample.
  task automatic streamBlock(input int blk, input bit gaps, input bit readPrev,
                             input bit ackLast, input bit clrLast);
    for (int idx = 0; idx < BLOCK_LEN; idx++) begin
      bit last;
      last    = (idx == BLOCK_LEN - 1);
      inValid = 1'b1;
      inData  = sampleVal(blk, idx);
      if (readPrev) begin
        expItem_t item;
        rdAddr   = ADDR_W'(idx);
        rdReq    = 1'b1;
        item.val = sampleVal(blk - 1, idx);
        item.tag = "R5 read during fill";
        expQ.push_back(item);
      end
      if (last) begin
        ackIrq     = ackLast;
        clrOverrun = clrLast;
      end
      @(posedge clk);
      @(negedge clk);
      inValid    = 1'b0;
      rdReq      = 1'b0;
      ackIrq     = 1'b0;
      clrOverrun = 1'b0;
      if (last) begin
        expBank = ~expBank;
        chk(irqPulse == 1'b1, "R3 irq at swap", 32'(irqPulse), 1);
        chk(cpuBank == expBank, "R3 bank swap", 32'(cpuBank), 32'(expBank));
        idle(1);
        chk(irqPulse == 1'b0, "R3 irq single", 32'(irqPulse), 0);
      end else begin
        if (irqPulse !== 1'b0 || cpuBank !== expBank) begin
          chk(1'b0, "R2 early swap", {30'd0, irqPulse, cpuBank}, {31'd0, expBank});
        end
        if (gaps) begin
          idle(1);
          if (irqPulse !== 1'b0) chk(1'b0, "R2 gap", 32'(irqPulse), 0);
        end
      end
    end
  endtask

  task automatic readBlock(input int blk);
    for (int idx = 0; idx < BLOCK_LEN; idx++) begin
      expItem_t item;
      rdAddr   = ADDR_W'(idx);
      rdReq    = 1'b1;
      item.val = sampleVal(blk, idx);
      item.tag = "R4 readback";
      expQ.push_back(item);
      @(posedge clk);
      @(negedge clk);
    end
    rdReq = 1'b0;
    idle(2);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    idle(2);
    // R1: reset state
    chk(inReady == 1'b0, "R1 ready", 32'(inReady), 0);
    chk(irqPulse == 1'b0, "R1 irq", 32'(irqPulse), 0);
    chk(overrun == 1'b0, "R1 overrun", 32'(overrun), 0);
    chk(cpuBank == 1'b1, "R1 bank", 32'(cpuBank), 1);
    rstN = 1'b1;
    idle(1);
    chk(inReady == 1'b1, "R2 ready", 32'(inReady), 1);

    // Block 0 with idle gaps (R1, R2, R3)
    streamBlock(0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(overrun == 1'b0, "R6 first block", 32'(overrun), 0);
    pulseAck();

    // Block 1 while reading block 0 (R5); acked before, so no overrun (R6)
    streamBlock(1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(overrun == 1'b0, "R6 acked", 32'(overrun), 0);

    // Block 2 without ack: overrun (R6)
    streamBlock(2, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(overrun == 1'b1, "R6 overrun set", 32'(overrun), 1);
    idle(5);
    chk(overrun == 1'b1, "R7 sticky", 32'(overrun), 1);
    pulseClr();
    chk(overrun == 1'b0, "R7 cleared", 32'(overrun), 0);

    // Ack, then a spurious ack (R8)
    pulseAck();
    pulseAck();
    chk(cpuBank == expBank, "R8 bank", 32'(cpuBank), 32'(expBank));
    chk(overrun == 1'b0, "R8 overrun", 32'(overrun), 0);
    streamBlock(3, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(overrun == 1'b0, "R8 no overrun", 32'(overrun), 0);

    // Block 4 without ack, clear on same edge: set wins (R7)
    streamBlock(4, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(overrun == 1'b1, "R7 set wins", 32'(overrun), 1);
    pulseClr();
    chk(overrun == 1'b0, "R7 clear", 32'(overrun), 0);

    // Block 5 with ack on the swap edge (R6)
    streamBlock(5, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(overrun == 1'b0, "R6 ack at swap", 32'(overrun), 0);

    readBlock(5);
    chk(expQ.size() == 0, "R4 all responses", 32'(expQ.size()), 0);
    finishRun();
  end

endmodule